// File: doc/BRIEF.md
# Transition-Triggered Sample Recorder

The recorder watches eight asynchronous logic channels and samples them on an internal sample tick made by dividing the system clock. Rather than filling memory with every sample, it writes a record to an external word-wide synchronous SRAM only when the sampled channel levels differ from the levels in the last stored record. Each record packs the channel levels, a wrapping timestamp counted in sample ticks since the capture started, and a status byte. A host can rebuild the full waveform from these records.

Capture is driven by three single-cycle commands: start, stop and clear. The first tick after a start always yields a record that carries a start marker. If the timestamp is about to wrap while the channels stay quiet, a record is forced and flagged, so that no elapsed time is lost. When the last memory slot is written, capture halts and a full flag is raised until a clear. Triggering, readback and the host protocol are handled elsewhere.

Top module: `trans_recorder`

## Requirements
- R1: `sample_tick_o` is high for exactly one clock in every `DIV` clocks, and it runs whether or not a capture is active. Each channel passes through a two-flop synchroniser before any comparison.
- R2: The record word is `{status[7:0], timestamp[TS_W-1:0], levels[CH_W-1:0]}`, with the levels in the low bits. Status bit 0 is the start marker and status bit 1 is the wrap flag. All other status bits are zero.
- R3: On the first tick after a start is accepted, a record is always stored. That record carries timestamp 0 and has status bit 0 set.
- R4: On any later tick while running, a record is stored only if the synchronised levels differ from those of the last stored record or the timestamp is all ones. No record is written at any other time.
- R5: The timestamp resets to 0 on start and advances by one on every tick while running, wrapping at 2^TS_W. A tick at timestamp all-ones stores a record with status bit 1 set, even when no channel changed.
- R6: Each record goes to the address equal to `rec_count_o` before the write. The count then increases by exactly one, and `mem_we_o` pulses for one clock per record in the clock after the tick.
- R7: When the record that fills slot 2^ADDR_W-1 is written, capture stops: `running_o` falls, `full_o` rises and `rec_count_o` reads 2^ADDR_W. While full, start is ignored and nothing is written.
- R8: Stop while running returns the recorder to idle, and no record is stored from that cycle on. Stop wins over a tick in the same cycle. Start while running, and stop while idle, have no effect. A new start after a stop appends after the existing records.
- R9: Clear has priority over every other command. In the next clock it leaves the recorder idle with count 0 and `full_o` low.
- R10: After reset the recorder is idle, with `running_o`, `full_o` and `mem_we_o` low and `rec_count_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_i | input | CH_W | Asynchronous channel levels |
| start_i | input | 1 | Start capture command, one-cycle pulse |
| stop_i | input | 1 | Stop capture command, one-cycle pulse |
| clear_i | input | 1 | Return to idle and empty the memory |
| sample_tick_o | output | 1 | Sample-enable strobe, one clock per DIV clocks |
| mem_we_o | output | 1 | SRAM write enable |
| mem_addr_o | output | ADDR_W | SRAM write address |
| mem_wdata_o | output | CH_W+TS_W+8 | SRAM write data (one record) |
| running_o | output | 1 | Capture active |
| full_o | output | 1 | Memory exhausted, capture halted |
| rec_count_o | output | ADDR_W+1 | Number of records stored |

## Verification
The bench holds the channels steady for more than two full timestamp periods. A design that misses the forced wrap record stores only the start record, and one that flags it at the wrong value shows a wrap bit with a timestamp other than all ones. It fills the memory with random transitions and then sends start again. An off-by-one in the full test either overwrites slot 0 or stops one record short, and a leaky full state writes after the start. It also restarts after a stop and clears in the middle of a run. A recorder that loses the start marker, or resets the address on start, or keeps counting after a clear, then produces records or counts that differ from the bench model.

// File: rtl/rec_pkg.sv
package rec_pkg;
  localparam int unsigned ST_W     = 8;
  localparam int unsigned ST_START = 0;
  localparam int unsigned ST_WRAP  = 1;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FULL = 2'd2
  } cap_state_e;
endpackage

// File: rtl/tick_div.sv
module tick_div #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  // R1: strobe never lasts two clocks
  a_r1_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/chan_sync.sv
module chan_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_ch
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/change_det.sv
module change_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  input  logic         store_i,
  output logic         differ_o
);
  logic [W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_q <= '0;
    else if (store_i) last_q <= cur_i;
  end

  assign differ_o = (cur_i != last_q);

  // R4: a stored level set becomes the reference
  a_r4_ref_updates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && $stable(cur_i)) |=> !differ_o);
endmodule

// File: rtl/rec_ctrl.sv
module rec_ctrl
  import rec_pkg::*;
#(
  parameter int unsigned CH_W   = 8,
  parameter int unsigned TS_W   = 16,
  parameter int unsigned ADDR_W = 18
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          stop_i,
  input  logic                          clear_i,
  input  logic                          tick_i,
  input  logic                          differ_i,
  input  logic [CH_W-1:0]               samp_i,
  output logic                          store_o,
  output logic                          we_o,
  output logic [ADDR_W-1:0]             addr_o,
  output logic [CH_W+TS_W+ST_W-1:0]     wdata_o,
  output logic                          running_o,
  output logic                          full_o,
  output logic [ADDR_W:0]               count_o
);
  localparam int unsigned REC_W = CH_W + TS_W + ST_W;
  localparam int unsigned CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH = CNT_W'(1) << ADDR_W;

  cap_state_e        state_q;
  logic              first_q;
  logic [TS_W-1:0]   ts_q;
  logic [CNT_W-1:0]  ptr_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REC_W-1:0]  data_q;

  logic             wrap;
  logic             last_slot;
  logic [ST_W-1:0]  status;

  assign wrap      = (ts_q == '1);
  assign last_slot = (ptr_q == DEPTH - CNT_W'(1));
  assign store_o   = (state_q == S_RUN) && !clear_i && !stop_i && tick_i
                     && (first_q || differ_i || wrap);

  always_comb begin
    status           = '0;
    status[ST_START] = first_q;
    status[ST_WRAP]  = wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      first_q <= 1'b0;
      ts_q    <= '0;
      ptr_q   <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      we_q <= store_o;
      if (store_o) begin
        addr_q  <= ptr_q[ADDR_W-1:0];
        data_q  <= {status, ts_q, samp_i};
        ptr_q   <= ptr_q + CNT_W'(1);
        first_q <= 1'b0;
      end
      if (clear_i) begin
        state_q <= S_IDLE;
        ptr_q   <= '0;
      end else begin
        unique case (state_q)
          S_IDLE: if (start_i) begin
            state_q <= S_RUN;
            first_q <= 1'b1;
            ts_q    <= '0;
          end
          S_RUN: begin
            if (stop_i) state_q <= S_IDLE;
            else if (tick_i) begin
              ts_q <= ts_q + TS_W'(1);
              if (store_o && last_slot) state_q <= S_FULL;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign we_o      = we_q;
  assign addr_o    = addr_q;
  assign wdata_o   = data_q;
  assign running_o = (state_q == S_RUN);
  assign full_o    = (state_q == S_FULL);
  assign count_o   = ptr_q;

  // R6: every write advances the count by one
  a_r6_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> (ptr_q == $past(ptr_q) + CNT_W'(1)));
  // R6: written address is the pre-write count
  a_r6_addr_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> (addr_q == $past(ptr_q[ADDR_W-1:0])));
  // R7: full only with every slot used
  a_r7_full_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (ptr_q == DEPTH));
  // R5: wrap flag only at all-ones timestamp
  a_r5_wrap_ts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && data_q[CH_W+TS_W+ST_WRAP]) |-> (data_q[CH_W +: TS_W] == '1));
  // R3: start marker carries timestamp zero
  a_r3_start_ts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && data_q[CH_W+TS_W+ST_START]) |-> (data_q[CH_W +: TS_W] == '0));
  // R8: stop halts capture and writing
  a_r8_stop_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && stop_i && !clear_i) |=> (!running_o && !we_q));
  // R9: clear empties the count
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (ptr_q == '0 && !running_o && !full_o));
endmodule

// File: rtl/trans_recorder.sv
module trans_recorder
  import rec_pkg::*;
#(
  parameter int unsigned CH_W   = 8,
  parameter int unsigned TS_W   = 16,
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DIV    = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [CH_W-1:0]            chan_i,
  input  logic                       start_i,
  input  logic                       stop_i,
  input  logic                       clear_i,
  output logic                       sample_tick_o,
  output logic                       mem_we_o,
  output logic [ADDR_W-1:0]          mem_addr_o,
  output logic [CH_W+TS_W+ST_W-1:0]  mem_wdata_o,
  output logic                       running_o,
  output logic                       full_o,
  output logic [ADDR_W:0]            rec_count_o
);
  logic            tick;
  logic [CH_W-1:0] samp;
  logic            store;
  logic            differ;

  tick_div #(.DIV(DIV)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  chan_sync #(.W(CH_W), .STAGES(SYNC_N)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (chan_i),
    .q_o    (samp)
  );

  change_det #(.W(CH_W)) i_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cur_i    (samp),
    .store_i  (store),
    .differ_o (differ)
  );

  rec_ctrl #(.CH_W(CH_W), .TS_W(TS_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .clear_i   (clear_i),
    .tick_i    (tick),
    .differ_i  (differ),
    .samp_i    (samp),
    .store_o   (store),
    .we_o      (mem_we_o),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_wdata_o),
    .running_o (running_o),
    .full_o    (full_o),
    .count_o   (rec_count_o)
  );

  assign sample_tick_o = tick;
endmodule

// File: tb/test_trans_recorder.sv
`timescale 1ns/1ps
module test_trans_recorder;
  localparam int unsigned CH_W   = 8;
  localparam int unsigned TS_W   = 8;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DIV    = 4;
  localparam int unsigned REC_W  = CH_W + TS_W + 8;
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned TS_MAX = (1 << TS_W) - 1;

  logic clk = 0, rst_ni = 0;
  logic [CH_W-1:0] chan_i = '0;
  logic start_i = 0, stop_i = 0, clear_i = 0;
  logic sample_tick_o, mem_we_o, running_o, full_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [REC_W-1:0]  mem_wdata_o;
  logic [ADDR_W:0]   rec_count_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  trans_recorder #(.CH_W(CH_W), .TS_W(TS_W), .ADDR_W(ADDR_W), .DIV(DIV)) i_trans_recorder (
    .clk_i(clk), .rst_ni(rst_ni), .chan_i(chan_i), .start_i(start_i), .stop_i(stop_i),
    .clear_i(clear_i), .sample_tick_o(sample_tick_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .running_o(running_o),
    .full_o(full_o), .rec_count_o(rec_count_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // reference model, stepped at negedge for the following posedge
  int unsigned     m_state = 0;   // 0 idle, 1 run, 2 full
  bit              m_first = 0;
  int unsigned     m_ts = 0;
  int unsigned     m_cnt = 0;
  logic [CH_W-1:0] m_last = '0;
  bit              p_valid = 0;
  logic [REC_W-1:0]  p_data;
  logic [ADDR_W-1:0] p_addr;
  string           p_tag;

  function automatic logic [REC_W-1:0] mk_rec(input bit st, input bit wr,
                                              input int unsigned ts, input logic [CH_W-1:0] lv);
    logic [7:0] s;
    s = '0; s[0] = st; s[1] = wr;
    return {s, TS_W'(ts), lv};
  endfunction

  always @(negedge clk) if (rst_ni && !done) begin
    chk(running_o == (m_state == 1), "R8", "running_o", 64'(running_o), 64'(m_state == 1));
    chk(full_o == (m_state == 2), "R7", "full_o", 64'(full_o), 64'(m_state == 2));
    chk(rec_count_o == (ADDR_W+1)'(m_cnt), "R6", "rec_count_o", 64'(rec_count_o), 64'(m_cnt));
    if (p_valid) begin
      chk(mem_we_o, "R4", "expected write missing", 64'(mem_we_o), 64'd1);
      if (mem_we_o) begin
        chk(mem_wdata_o == p_data, p_tag, "R2 record word", 64'(mem_wdata_o), 64'(p_data));
        chk(mem_addr_o == p_addr, "R6", "write address", 64'(mem_addr_o), 64'(p_addr));
      end
    end else
      chk(!mem_we_o, "R4", "unexpected write", 64'(mem_we_o), 64'd0);
    p_valid = 0;
    if (clear_i) begin
      m_state = 0; m_cnt = 0;
    end else if (m_state == 0) begin
      if (start_i) begin m_state = 1; m_first = 1; m_ts = 0; end
    end else if (m_state == 1) begin
      if (stop_i) m_state = 0;
      else if (sample_tick_o) begin
        bit wr;
        wr = (m_ts == TS_MAX);
        if (m_first || chan_i != m_last || wr) begin
          p_valid = 1;
          p_data  = mk_rec(m_first, wr, m_ts, chan_i);
          p_addr  = ADDR_W'(m_cnt);
          p_tag   = m_first ? "R3" : (wr ? "R5" : "R4");
          m_last  = chan_i; m_first = 0; m_cnt++;
          if (m_cnt == DEPTH) m_state = 2;
        end
        m_ts = (m_ts + 1) % (TS_MAX + 1);
      end
    end
  end

  task automatic wait_tick();
    do @(negedge clk); while (!sample_tick_o);
    @(posedge clk); #1;
  endtask

  task automatic pulse_start(); start_i = 1; @(posedge clk); #1; start_i = 0; endtask
  task automatic pulse_stop();  stop_i  = 1; @(posedge clk); #1; stop_i  = 0; endtask
  task automatic pulse_clear(); clear_i = 1; @(posedge clk); #1; clear_i = 0; endtask

  task automatic rand_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      wait_tick();
      if ($urandom_range(1, 0) == 1) chan_i = CH_W'($urandom);
    end
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7391));
    repeat (4) @(posedge clk);
    #1 rst_ni = 1;
    @(negedge clk);
    chk(!running_o && !full_o && !mem_we_o && rec_count_o == 0, "R10", "reset state",
        {running_o, full_o, mem_we_o, 32'(rec_count_o)}, 64'd0);

    // R1: strobe period
    for (int k = 0; k < 2; k++) begin
      int gap;
      do @(negedge clk); while (!sample_tick_o);
      gap = 0;
      do begin @(negedge clk); gap++; end while (!sample_tick_o);
      chk(gap == DIV, "R1", "tick period", 64'(gap), 64'(DIV));
    end
    @(posedge clk); #1;

    // R8: idle stop and channel activity do nothing
    pulse_stop();
    rand_ticks(6);
    @(negedge clk);
    chk(rec_count_o == 0 && !running_o, "R8", "idle stays idle", 64'(rec_count_o), 64'd0);
    @(posedge clk); #1;

    // R3/R4: first capture with random transitions
    pulse_start();
    rand_ticks(12);
    pulse_start();                     // ignored while running (R8)
    rand_ticks(8);
    pulse_stop();
    rand_ticks(4);
    @(negedge clk);
    chk(!running_o, "R8", "stopped after stop", 64'(running_o), 64'd0);
    @(posedge clk); #1;

    // restart appends with a new start marker
    pulse_start();
    rand_ticks(10);

    // R9: clear mid-run
    pulse_clear();
    @(negedge clk);
    chk(rec_count_o == 0 && !running_o && !full_o, "R9", "clear result",
        {running_o, full_o, 32'(rec_count_o)}, 64'd0);
    @(posedge clk); #1;

    // R5: quiet channels across two wraps
    pulse_start();
    for (int i = 0; i < 600; i++) wait_tick();
    @(negedge clk);
    chk(rec_count_o == 3, "R5", "records after 600 quiet ticks", 64'(rec_count_o), 64'd3);
    @(posedge clk); #1;

    // R7: fill the memory
    for (int i = 0; i < 300 && !full_o; i++) begin
      wait_tick();
      chan_i = ~chan_i ^ CH_W'($urandom_range(3, 0));
    end
    @(negedge clk);
    chk(full_o && !running_o && rec_count_o == DEPTH, "R7", "full after fill",
        {full_o, running_o, 32'(rec_count_o)}, {1'b1, 1'b0, 32'(DEPTH)});
    @(posedge clk); #1;
    pulse_start();
    rand_ticks(8);
    @(negedge clk);
    chk(full_o && rec_count_o == DEPTH, "R7", "start ignored when full",
        64'(rec_count_o), 64'(DEPTH));
    @(posedge clk); #1;

    // R9: clear from full, then a short random run
    pulse_clear();
    @(negedge clk);
    chk(!full_o && rec_count_o == 0, "R9", "clear from full", 64'(full_o), 64'd0);
    @(posedge clk); #1;
    pulse_start();
    rand_ticks(20);
    pulse_stop();
    repeat (3) @(posedge clk);
    #1;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule